// File: doc/BRIEF.md
# Single-Cycle Processor Core

This block is a 32-bit processor core that finishes one instruction in every clock cycle. In that cycle it fetches the instruction word, reads its register operands and decodes it. It then runs the ALU, accesses data memory if the instruction needs to, and writes the result back. The instruction set is kept to five operations: register add, register subtract, load word, store word, and branch when two registers are equal.

Before the core runs, both memories are filled through one load port while reset is held high. A select bit on that port steers each word to the instruction store or to the data store. Once reset is released, the core starts executing at address 0. Two debug outputs let a testbench follow execution: one shows the current program counter, the other shows the register write the current instruction will commit at the next edge.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high the program counter reads 0 and no register write is signalled. After `rst` falls, the first instruction executed is the one at address 0.
- R2: An instruction that is not a taken branch advances the program counter by 4. The instruction word is taken from bits 31:26 (opcode), 25:21 (first source), 20:16 (second source or load destination), 15:11 (R-type destination), 5:0 (function) and 15:0 (immediate).
- R3: Opcode 0x00 writes the result to the register in bits 15:11. Function 0x22 writes first source minus second source. Any other function value writes their sum.
- R4: Opcode 0x23 writes the data word at address (first source + sign-extended 16-bit immediate) into the register in bits 20:16.
- R5: Opcode 0x2B stores the second-source register at address (first source + sign-extended immediate) and writes no register.
- R6: Register 0 always reads as zero. A write aimed at it is signalled on the debug port but leaves the register unchanged.
- R7: Opcode 0x04 compares both source registers by subtraction. When they are equal, the next program counter is (PC+4) + (sign-extended immediate × 4); otherwise it is PC+4. No register is written.
- R8: Any other opcode writes neither a register nor data memory, and the program counter advances by 4.
- R9: Data memory selects its word with address bits [log2(depth)+1:2], so byte addresses one memory size apart refer to the same word.
- R10: With `rst` high, a pulse on `load_en` writes `load_data` to word `load_addr`. The word goes to instruction memory when `load_sel` is 0 and to data memory when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write strobe for the memory load port |
| load_sel | input | 1 | 0 selects instruction memory, 1 selects data memory |
| load_addr | input | LAW | Word index for the load port |
| load_data | input | 32 | Word to be written through the load port |
| dbg_pc | output | 32 | Current program counter |
| dbg_wr_en | output | 1 | The current instruction writes a register at the next edge |
| dbg_wr_reg | output | 5 | Destination register of that write |
| dbg_wr_data | output | 32 | Value of that write |

## Verification
The bench builds the core with a 32-word instruction memory and a 16-word data memory. With a data memory that small, a load from byte address 64 must return the word stored at address 0, so the address-wrap behaviour can be observed directly. The program uses forward, backward and not-taken branches, a negative load offset, negative data values, a write aimed at register 0 and an undefined opcode. Every cycle is compared against a model that works only from the requirements.

// File: rtl/sc_pkg.sv
`timescale 1ns/1ps
package sc_pkg;

    localparam int XLEN = 32;
    localparam int RIDX = 5;

    typedef enum logic [5:0] {
        OP_RTYPE = 6'h00,
        OP_BEQ   = 6'h04,
        OP_LW    = 6'h23,
        OP_SW    = 6'h2B
    } opcode_e;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;

    typedef enum logic {
        ALU_ADD = 1'b0,
        ALU_SUB = 1'b1
    } alu_op_e;

    typedef struct packed {
        logic [5:0]      opcode;
        logic [RIDX-1:0] rs;
        logic [RIDX-1:0] rt;
        logic [RIDX-1:0] rd;
        logic [4:0]      shamt;
        logic [5:0]      funct;
    } instr_t;

    typedef struct packed {
        logic    reg_write;
        logic    alu_src;
        logic    mem_read;
        logic    mem_write;
        logic    mem_to_reg;
        logic    reg_dst;
        logic    branch;
        alu_op_e alu_op;
    } ctrl_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic ctrl_t decode(input logic [5:0] op, input logic [5:0] fn);
        ctrl_t c;
        c = '0;
        c.alu_op = ALU_ADD;
        case (opcode_e'(op))
            OP_RTYPE: begin
                c.reg_write = 1'b1;
                c.reg_dst   = 1'b1;
                c.alu_op    = (fn == FN_SUB) ? ALU_SUB : ALU_ADD;
            end
            OP_LW: begin
                c.reg_write  = 1'b1;
                c.alu_src    = 1'b1;
                c.mem_read   = 1'b1;
                c.mem_to_reg = 1'b1;
            end
            OP_SW: begin
                c.alu_src   = 1'b1;
                c.mem_write = 1'b1;
            end
            OP_BEQ: begin
                c.branch = 1'b1;
                c.alu_op = ALU_SUB;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sc_fetch.sv
`timescale 1ns/1ps
module sc_fetch
    import sc_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            imem_we,
    input  logic [AW-1:0]   imem_waddr,
    input  logic [XLEN-1:0] imem_wdata,
    input  logic [XLEN-1:0] imm_ext,
    input  logic            take_br,
    output logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] pc_plus4,
    output logic [XLEN-1:0] br_target,
    output logic [XLEN-1:0] instr
);

    logic [XLEN-1:0] mem [DEPTH];
    logic [XLEN-1:0] pc_q;

    always_ff @(posedge clk) begin
        if (imem_we) begin
            mem[imem_waddr] <= imem_wdata;
        end
    end

    // sequential adder, separate from the ALU
    assign pc_plus4  = pc_q + 32'd4;
    // branch adder: word offset scaled to bytes
    assign br_target = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
    assign instr     = mem[pc_q[AW+1:2]];
    assign pc        = pc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            pc_q <= take_br ? br_target : pc_plus4;
        end
    end

endmodule

// File: rtl/sc_regfile.sv
`timescale 1ns/1ps
module sc_regfile
    import sc_pkg::*;
#(
    parameter int NREG = 32,
    localparam int AW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   ra1,
    input  logic [AW-1:0]   ra2,
    output logic [XLEN-1:0] rd1,
    output logic [XLEN-1:0] rd2,
    input  logic            we,
    input  logic [AW-1:0]   wa,
    input  logic [XLEN-1:0] wd
);

    logic [XLEN-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= '0;
            end
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

endmodule

// File: rtl/sc_alu.sv
`timescale 1ns/1ps
module sc_alu
    import sc_pkg::*;
(
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_op_e         op,
    output logic [XLEN-1:0] y,
    output logic            zero
);

    always_comb begin
        case (op)
            ALU_SUB: y = a - b;
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_dmem.sv
`timescale 1ns/1ps
module sc_dmem
    import sc_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            we,
    input  logic            re,
    input  logic [XLEN-1:0] addr,
    input  logic [XLEN-1:0] wd,
    output logic [XLEN-1:0] rd,
    input  logic            ld_we,
    input  logic [AW-1:0]   ld_addr,
    input  logic [XLEN-1:0] ld_data
);

    logic [XLEN-1:0] mem [DEPTH];
    logic [AW-1:0]   idx;

    // word index from byte address; higher bits alias
    assign idx = addr[AW+1:2];

    always_ff @(posedge clk) begin
        if (ld_we) begin
            mem[ld_addr] <= ld_data;
        end else if (we) begin
            mem[idx] <= wd;
        end
    end

    assign rd = re ? mem[idx] : '0;

endmodule

// File: rtl/sc_core.sv
`timescale 1ns/1ps
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_DEPTH = 64,
    parameter int DMEM_DEPTH = 64,
    localparam int IA_W = $clog2(IMEM_DEPTH),
    localparam int DA_W = $clog2(DMEM_DEPTH),
    localparam int LAW = (IA_W > DA_W) ? IA_W : DA_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_en,
    input  logic            load_sel,
    input  logic [LAW-1:0]  load_addr,
    input  logic [31:0]     load_data,
    output logic [31:0]     dbg_pc,
    output logic            dbg_wr_en,
    output logic [4:0]      dbg_wr_reg,
    output logic [31:0]     dbg_wr_data
);

    logic [XLEN-1:0] pc_q, pc_plus4, br_target, instr;
    logic [XLEN-1:0] imm_ext, rs_val, rt_val, alu_b, alu_y, mem_rd, wb_data;
    logic [RIDX-1:0] dest;
    logic            zero, take_br, rf_we, dm_we;
    instr_t          f;
    ctrl_t           ctrl;

    assign f       = instr_t'(instr);
    assign ctrl    = decode(f.opcode, f.funct);
    assign imm_ext = sext16(instr[15:0]);
    assign take_br = ctrl.branch & zero;
    assign rf_we   = ctrl.reg_write & ~rst;
    assign dm_we   = ctrl.mem_write & ~rst;

    sc_fetch #(.DEPTH(IMEM_DEPTH)) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .imem_we    (rst & load_en & ~load_sel),
        .imem_waddr (load_addr[IA_W-1:0]),
        .imem_wdata (load_data),
        .imm_ext    (imm_ext),
        .take_br    (take_br),
        .pc         (pc_q),
        .pc_plus4   (pc_plus4),
        .br_target  (br_target),
        .instr      (instr)
    );

    sc_regfile #(.NREG(32)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra1 (f.rs),
        .ra2 (f.rt),
        .rd1 (rs_val),
        .rd2 (rt_val),
        .we  (rf_we),
        .wa  (dest),
        .wd  (wb_data)
    );

    // operand and destination steering
    assign alu_b = ctrl.alu_src ? imm_ext : rt_val;
    assign dest  = ctrl.reg_dst ? f.rd : f.rt;

    sc_alu u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (zero)
    );

    sc_dmem #(.DEPTH(DMEM_DEPTH)) u_dmem (
        .clk     (clk),
        .we      (dm_we),
        .re      (ctrl.mem_read),
        .addr    (alu_y),
        .wd      (rt_val),
        .rd      (mem_rd),
        .ld_we   (rst & load_en & load_sel),
        .ld_addr (load_addr[DA_W-1:0]),
        .ld_data (load_data)
    );

    assign wb_data = ctrl.mem_to_reg ? mem_rd : alu_y;

    assign dbg_pc      = pc_q;
    assign dbg_wr_en   = rf_we;
    assign dbg_wr_reg  = dest;
    assign dbg_wr_data = wb_data;

endmodule

// File: rtl/sc_core_chk.sv
`timescale 1ns/1ps
module sc_core_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc,
    input logic [31:0] instr,
    input logic [31:0] rs_val,
    input logic        rf_we,
    input logic        dm_we,
    input logic        take_br,
    input logic [31:0] br_target
);

    logic [5:0] op;
    logic       known_op;
    assign op       = instr[31:26];
    assign known_op = (op == 6'h00) || (op == 6'h23) || (op == 6'h2B) || (op == 6'h04);

    assert_pc_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> pc == 32'd0);

    assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(take_br)) |-> pc == $past(pc) + 32'd4);

    assert_pc_aligned_R2: assert property (@(posedge clk) disable iff (rst)
        pc[1:0] == 2'b00);

    assert_store_only_R5: assert property (@(posedge clk) disable iff (rst)
        (op == 6'h2B) |-> (dm_we && !rf_we));

    assert_zero_reg_R6: assert property (@(posedge clk) disable iff (rst)
        (instr[25:21] == 5'd0) |-> rs_val == 32'd0);

    assert_branch_target_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(take_br)) |-> pc == $past(br_target));

    assert_unknown_op_R8: assert property (@(posedge clk) disable iff (rst)
        !known_op |-> (!rf_we && !dm_we));

endmodule

bind sc_core sc_core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .pc        (pc_q),
    .instr     (instr),
    .rs_val    (rs_val),
    .rf_we     (rf_we),
    .dm_we     (dm_we),
    .take_br   (take_br),
    .br_target (br_target)
);

// File: tb/sc_core_tb.sv
`timescale 1ns/1ps
module sc_core_tb;

    localparam int IMEM  = 32;
    localparam int DMEM  = 16;
    localparam int IAW   = $clog2(IMEM);
    localparam int DAW   = $clog2(DMEM);
    localparam int LAW   = (IAW > DAW) ? IAW : DAW;
    localparam int STEPS = 30;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           load_en = 1'b0;
    logic           load_sel = 1'b0;
    logic [LAW-1:0] load_addr = '0;
    logic [31:0]    load_data = '0;
    logic [31:0]    dbg_pc, dbg_wr_data;
    logic           dbg_wr_en;
    logic [4:0]     dbg_wr_reg;

    int checks = 0;
    int fails  = 0;

    logic [31:0] prog [IMEM];
    logic [31:0] dinit [DMEM];

    logic [31:0] q_pc[$];
    logic        q_we[$];
    logic [4:0]  q_reg[$];
    logic [31:0] q_data[$];
    string       q_tag[$];

    always #2 clk = ~clk;

    sc_core #(.IMEM_DEPTH(IMEM), .DMEM_DEPTH(DMEM)) u_dut (
        .clk (clk), .rst (rst),
        .load_en (load_en), .load_sel (load_sel),
        .load_addr (load_addr), .load_data (load_data),
        .dbg_pc (dbg_pc), .dbg_wr_en (dbg_wr_en),
        .dbg_wr_reg (dbg_wr_reg), .dbg_wr_data (dbg_wr_data)
    );

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    // reference model built from the requirements; fills the scoreboard
    task automatic drive_expected();
        logic [31:0] regs [32];
        logic [31:0] dm [DMEM];
        logic [31:0] pc, npc, ins, se, a, b, addr, wd;
        logic [5:0]  op, fn;
        logic [4:0]  wr;
        logic        we;
        string       tag;
        for (int i = 0; i < 32; i++) regs[i] = '0;
        for (int i = 0; i < DMEM; i++) dm[i] = dinit[i];
        pc = '0;
        for (int s = 0; s < STEPS; s++) begin
            ins = prog[pc[IAW+1:2]];
            op  = ins[31:26];
            fn  = ins[5:0];
            se  = {{16{ins[15]}}, ins[15:0]};
            a   = regs[ins[25:21]];
            b   = regs[ins[20:16]];
            npc = pc + 32'd4;
            we  = 1'b0; wr = '0; wd = '0; tag = "R2";
            addr = a + se;
            case (op)
                6'h00: begin
                    we = 1'b1; wr = ins[15:11]; tag = "R3";
                    wd = (fn == 6'h22) ? a - b : a + b;
                end
                6'h23: begin
                    we = 1'b1; wr = ins[20:16];
                    wd = dm[addr[DAW+1:2]];
                    tag = (addr >= 32'(DMEM * 4)) ? "R9" : "R4";
                end
                6'h2B: begin
                    dm[addr[DAW+1:2]] = b; tag = "R5";
                end
                6'h04: begin
                    if (a == b) npc = npc + {se[29:0], 2'b00};
                    tag = "R7";
                end
                default: tag = "R8";
            endcase
            if (we && wr == 5'd0) tag = "R6";
            if (we && wr != 5'd0) regs[wr] = wd;
            if (s == 0) tag = "R10";
            q_pc.push_back(pc); q_we.push_back(we); q_reg.push_back(wr);
            q_data.push_back(wd); q_tag.push_back(tag);
            pc = npc;
        end
    endtask

    // monitor: one expected item per executed cycle
    always @(negedge clk) begin
        if (!rst && q_pc.size() > 0) begin
            logic [31:0] e_pc, e_data;
            logic        e_we;
            logic [4:0]  e_reg;
            string       e_tag;
            e_pc = q_pc.pop_front(); e_we = q_we.pop_front(); e_reg = q_reg.pop_front();
            e_data = q_data.pop_front(); e_tag = q_tag.pop_front();
            checks++;
            if (dbg_pc !== e_pc || dbg_wr_en !== e_we ||
                (e_we && (dbg_wr_reg !== e_reg || dbg_wr_data !== e_data))) begin
                fails++;
                $display("FAIL %s: got pc=%h we=%b reg=%0d data=%h, expected pc=%h we=%b reg=%0d data=%h",
                         e_tag, dbg_pc, dbg_wr_en, dbg_wr_reg, dbg_wr_data, e_pc, e_we, e_reg, e_data);
            end
        end
    end

    task automatic check_reset();
        checks++;
        if (dbg_pc !== 32'd0 || dbg_wr_en !== 1'b0) begin
            fails++;
            $display("FAIL R1: got pc=%h we=%b, expected pc=00000000 we=0", dbg_pc, dbg_wr_en);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #80000;
        fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        for (int i = 0; i < IMEM; i++) prog[i] = '0;
        prog[0]  = enc_i(6'h23, 0, 1, 0);        // r1 = 5
        prog[1]  = enc_i(6'h23, 0, 2, 4);        // r2 = 7
        prog[2]  = enc_r(1, 2, 3, 6'h20);        // r3 = 12
        prog[3]  = enc_r(1, 2, 4, 6'h22);        // r4 = -2
        prog[4]  = enc_i(6'h23, 0, 5, 8);        // r5 = -16
        prog[5]  = enc_r(5, 2, 6, 6'h20);        // r6 = -9
        prog[6]  = enc_i(6'h2B, 0, 3, 20);       // mem word 5 = 12
        prog[7]  = enc_i(6'h23, 0, 7, 20);       // r7 = 12
        prog[8]  = enc_r(1, 2, 0, 6'h20);        // write to r0 dropped
        prog[9]  = enc_r(0, 1, 8, 6'h20);        // r8 = 5
        prog[10] = enc_i(6'h04, 0, 0, 2);        // forward to 13
        prog[11] = enc_i(6'h04, 0, 0, 3);        // forward to 15
        prog[12] = enc_r(1, 1, 9, 6'h20);        // skipped
        prog[13] = enc_i(6'h04, 0, 0, -3);       // backward to 11
        prog[14] = enc_r(1, 1, 9, 6'h20);        // skipped
        prog[15] = enc_i(6'h04, 1, 2, 5);        // not taken
        prog[16] = enc_i(6'h04, 3, 7, 1);        // taken to 18
        prog[17] = enc_r(1, 1, 10, 6'h20);       // skipped
        prog[18] = enc_i(6'h2B, 0, 6, 0);        // mem word 0 = -9
        prog[19] = enc_i(6'h23, 0, 11, 64);      // aliased read of word 0
        prog[20] = enc_i(6'h23, 3, 12, -8);      // negative offset, word 1
        prog[21] = 32'hFC00_0000;                // undefined opcode
        prog[22] = enc_r(4, 6, 13, 6'h22);       // r13 = 7
        prog[23] = enc_i(6'h04, 0, 0, -1);       // self loop
        for (int i = 0; i < DMEM; i++) dinit[i] = 32'h100 + 32'(i);
        dinit[0] = 32'd5;
        dinit[1] = 32'd7;
        dinit[2] = 32'hFFFF_FFF0;

        repeat (2) @(posedge clk);
        @(negedge clk);
        check_reset();
        for (int i = 0; i < IMEM; i++) begin
            load_en = 1'b1; load_sel = 1'b0; load_addr = LAW'(i); load_data = prog[i];
            @(negedge clk);
        end
        check_reset();
        for (int i = 0; i < DMEM; i++) begin
            load_en = 1'b1; load_sel = 1'b1; load_addr = LAW'(i); load_data = dinit[i];
            @(negedge clk);
        end
        load_en = 1'b0;
        check_reset();

        drive_expected();
        @(posedge clk);
        #1 rst = 1'b0;
        wait (q_pc.size() == 0);
        @(posedge clk);
        #1;
        finish_run();
    end

endmodule